// File: doc/BRIEF.md
# Carry-Chain Arithmetic Slice Array

This block is a chain of small arithmetic slices. Each slice covers two bit positions. At every position, two 4-input lookup tables build the two adder operands from four data inputs shared by that position, and a dedicated full adder sums them. The adder operands are therefore arbitrary functions of the local inputs rather than raw bits. This lets one configuration give a plain adder, an adder/subtractor, or an up/down counter with enable, with the control terms folded into the lookup tables.

Inside a slice, the carry moves with a 2-bit carry-select scheme. The 2-bit result is worked out once for an incoming carry of 0 and once for an incoming carry of 1, and the real carry then picks one of the two. The carry leaves each slice on a dedicated link to the next slice. The first slice takes its carry from a top-level pin.

The combinational sum and final carry drive output pins. A register bank behind them gives a registered copy of the sum and of the final carry, with a clock enable and a synchronous clear. Counter feedback is routed from the registered outputs back into a data input by the surrounding logic.

Every pin is a plain control, configuration or data pin. The chain has no flow control: a new set of inputs can be applied every cycle, and nothing can stall it.

Top module: `carry_chain_alu`

## Requirements
- R1: A lookup-table output equals bit `idx` of its 16-bit mask, where idx = {in3,in2,in1,in0} and in0 is the least significant index bit. At position k, the inputs in0..in3 are din_i[4k+0]..din_i[4k+3]. Mask bits [16k+15:16k] belong to position k. With mask_b_i all zero and cin_i=0, sum_o equals the vector of operand-A lookup outputs.
- R2: At each position, the sum bit and the carry to the next position equal opA + opB + carry-in, where opA comes from mask_a_i and opB from mask_b_i.
- R3: Within a slice, the 2-bit sum and the slice carry-out equal what a plain ripple of the two positions would give, for incoming carry 0 and for incoming carry 1.
- R4: Over the whole chain, {cout_o, sum_o} equals opA_vector + opB_vector + cin_i, where the vectors have width W = 2*NSLICE. With opA = din bit0, opB = din bit1 XOR din bit2, and cin_i = din bit2 = sub, the chain computes a+b when sub=0 and a-b when sub=1. When sub=1, cout_o=1 exactly when a >= b.
- R5: When ce_i=0, q_o and cout_q_o hold their values, whatever sclr_i is.
- R6: When ce_i=1 and sclr_i=1, q_o and cout_q_o become 0 on the next clock edge. sclr_i has no effect while ce_i=0.
- R7: When ce_i=1 and sclr_i=0, q_o takes the value of sum_o on the next clock edge.
- R8: When ce_i=1 and sclr_i=0, cout_q_o takes the value of cout_o on the next clock edge. This makes the final carry available as an ordinary data bit.
- R9: While rst_n is low, q_o and cout_q_o are 0.
- R10: In counter configuration, opA = din bit3 (fed from q_o) and opB = din bit1 AND NOT din bit0, with cin_i = en AND up, where en is din bit1 and up is din bit0. In this configuration, q_o counts +1 (up=1) or -1 (up=0) modulo 2^W on each enabled cycle and holds when en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for the output registers |
| sclr_i | input | 1 | Synchronous clear, effective only with ce_i |
| cin_i | input | 1 | Carry into the first slice |
| mask_a_i | input | 16*W | Operand-A lookup masks, 16 bits per position |
| mask_b_i | input | 16*W | Operand-B lookup masks, 16 bits per position |
| din_i | input | 4*W | Four data inputs per position |
| sum_o | output | W | Combinational sum |
| cout_o | output | 1 | Combinational carry out of the last slice |
| q_o | output | W | Registered sum |
| cout_q_o | output | 1 | Registered final carry |

## Verification
The hardest case to reach from the pins is a carry that propagates through every slice. In that case each carry-select mux must pass the carry it selects on to the next slice, rather than a value it worked out itself. The stimulus sets every operand-A table to constant one and every operand-B table to zero. It then toggles cin_i, so that the entire sum flips and cout_o follows the pin. Random adds and subtractions with near-equal operands also place long borrow chains over the slice boundaries. In the counter runs, the registered output is fed back through din_i, so wraps at 0 and at 2^W-1 drive a carry through the full chain.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int LUT_K     = 4;
  localparam int LUT_DEPTH = 1 << LUT_K;
  localparam int POS_PER_SLICE = 2;

  typedef struct packed {
    logic ce;
    logic sclr;
  } reg_ctl_t;
endpackage

// File: rtl/csa_lut.sv
module csa_lut #(
  parameter int K = csa_pkg::LUT_K,
  localparam int DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] mask,
  input  logic [K-1:0]     sel,
  output logic             f
);
  // sel[0] is the least significant index bit
  assign f = mask[sel];
endmodule

// File: rtl/csa_full_add.sv
module csa_full_add (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ c;
  assign co = (a & b) | (c & (a ^ b));
endmodule

// File: rtl/csa_slice.sv
module csa_slice #(
  parameter int POS = csa_pkg::POS_PER_SLICE,
  parameter int K   = csa_pkg::LUT_K,
  localparam int DEPTH = 1 << K
) (
  input  logic [POS*DEPTH-1:0] mask_a,
  input  logic [POS*DEPTH-1:0] mask_b,
  input  logic [POS*K-1:0]     din,
  input  logic                 cin,
  output logic [POS-1:0]       sum,
  output logic                 cout
);
  logic [POS-1:0] opa, opb;
  // chain 0 assumes carry-in 0, chain 1 assumes carry-in 1
  logic [1:0][POS:0]   rc;
  logic [1:0][POS-1:0] rs;

  for (genvar p = 0; p < POS; p++) begin : g_pos
    csa_lut #(.K(K)) u_la (
      .mask(mask_a[p*DEPTH +: DEPTH]), .sel(din[p*K +: K]), .f(opa[p]));
    csa_lut #(.K(K)) u_lb (
      .mask(mask_b[p*DEPTH +: DEPTH]), .sel(din[p*K +: K]), .f(opb[p]));
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chain
    assign rc[ch][0] = (ch != 0);
    for (genvar p = 0; p < POS; p++) begin : g_bit
      csa_full_add u_fa (
        .a(opa[p]), .b(opb[p]), .c(rc[ch][p]),
        .s(rs[ch][p]), .co(rc[ch][p+1]));
    end
  end

  assign sum  = cin ? rs[1] : rs[0];
  assign cout = cin ? rc[1][POS] : rc[0][POS];

  // R2, R3: selected result matches the arithmetic of the operands
  always_comb begin
    if (!$isunknown({opa, opb, cin})) begin
      p_csel_sum_r3: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + {{POS{1'b0}}, cin}))
        else $error("carry-select result mismatch");
    end
  end
endmodule

// File: rtl/csa_regbank.sv
module csa_regbank #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csa_pkg::reg_ctl_t ctl,
  input  logic [W-1:0]      d,
  input  logic              dc,
  output logic [W-1:0]      q,
  output logic              qc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      qc <= 1'b0;
    end else if (ctl.ce) begin
      if (ctl.sclr) begin
        q  <= '0;
        qc <= 1'b0;
      end else begin
        q  <= d;
        qc <= dc;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ce |=> ($stable(q) && $stable(qc)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce && ctl.sclr) |=> (q == '0 && !qc));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce && !ctl.sclr) |=> (q == $past(d)));
  p_carry_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce && !ctl.sclr) |=> (qc == $past(dc)));
endmodule

// File: rtl/carry_chain_alu.sv
module carry_chain_alu #(
  parameter int NSLICE = 4,
  localparam int POS   = csa_pkg::POS_PER_SLICE,
  localparam int K     = csa_pkg::LUT_K,
  localparam int DEPTH = csa_pkg::LUT_DEPTH,
  localparam int W     = NSLICE * POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             sclr_i,
  input  logic             cin_i,
  input  logic [W*DEPTH-1:0] mask_a_i,
  input  logic [W*DEPTH-1:0] mask_b_i,
  input  logic [W*K-1:0]   din_i,
  output logic [W-1:0]     sum_o,
  output logic             cout_o,
  output logic [W-1:0]     q_o,
  output logic             cout_q_o
);
  logic [NSLICE:0] carry;
  csa_pkg::reg_ctl_t ctl;

  assign carry[0] = cin_i;
  assign ctl.ce   = ce_i;
  assign ctl.sclr = sclr_i;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    csa_slice #(.POS(POS), .K(K)) u_slice (
      .mask_a(mask_a_i[s*POS*DEPTH +: POS*DEPTH]),
      .mask_b(mask_b_i[s*POS*DEPTH +: POS*DEPTH]),
      .din   (din_i[s*POS*K +: POS*K]),
      .cin   (carry[s]),
      .sum   (sum_o[s*POS +: POS]),
      .cout  (carry[s+1]));
  end

  assign cout_o = carry[NSLICE];

  csa_regbank #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .d(sum_o), .dc(cout_o), .q(q_o), .qc(cout_q_o));

  // R9: registers leave reset cleared
  p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_o == '0 && !cout_q_o));
endmodule

// File: tb/sim_carry_chain_alu.sv
`timescale 1ns/1ps
module sim_carry_chain_alu;
  localparam int NS = 4;
  localparam int W  = 2 * NS;
  localparam logic [W-1:0] WMASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_i = 1'b0, sclr_i = 1'b0, cin_i = 1'b0;
  logic [W*16-1:0] mask_a_i = '0, mask_b_i = '0;
  logic [W*4-1:0]  din_i = '0;
  logic [W-1:0] sum_o, q_o;
  logic cout_o, cout_q_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] eq = '0;
  logic eqc = 1'b0;

  always #5 clk = ~clk;

  carry_chain_alu #(.NSLICE(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sclr_i(sclr_i), .cin_i(cin_i),
    .mask_a_i(mask_a_i), .mask_b_i(mask_b_i), .din_i(din_i),
    .sum_o(sum_o), .cout_o(cout_o), .q_o(q_o), .cout_q_o(cout_q_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // kind 0: in0, 1: in1^in2, 2: in3, 3: in1&~in0, 4: const one, 5: zero
  function automatic logic [15:0] fmask(input int kind);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] x;
      x = 4'(i);
      case (kind)
        0: m[i] = x[0];
        1: m[i] = x[1] ^ x[2];
        2: m[i] = x[3];
        3: m[i] = x[1] & ~x[0];
        4: m[i] = 1'b1;
        default: m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic logic [W-1:0] lut_vec(input logic [W*16-1:0] m, input logic [W*4-1:0] d);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      int idx;
      idx = int'(d[4*k +: 4]);
      r[k] = m[16*k + idx];
    end
    return r;
  endfunction

  // Check combinational outputs, advance one clock, check registers
  task automatic tick(input string rtag);
    logic [W:0] full;
    #1;
    full = {1'b0, lut_vec(mask_a_i, din_i)} + {1'b0, lut_vec(mask_b_i, din_i)} + {{W{1'b0}}, cin_i};
    check("R2/R4 sum", 64'(sum_o), 64'(full[W-1:0]));
    check("R2/R4 cout", 64'(cout_o), 64'(full[W]));
    if (ce_i) begin
      eq  = sclr_i ? '0 : full[W-1:0];
      eqc = sclr_i ? 1'b0 : full[W];
    end
    @(posedge clk);
    #1;
    check(rtag, 64'(q_o), 64'(eq));
    check({rtag, " carry R8"}, 64'(cout_q_o), 64'(eqc));
  endtask

  task automatic set_din(input logic [W-1:0] b0, input logic [W-1:0] b1,
                         input logic [W-1:0] b2, input logic [W-1:0] b3);
    for (int k = 0; k < W; k++) din_i[4*k +: 4] = {b3[k], b2[k], b1[k], b0[k]};
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 q reset", 64'(q_o), 64'h0);
    check("R9 carry reset", 64'(cout_q_o), 64'h0);
    rst_n = 1'b1;
    ce_i = 1'b1;

    // R1: raw lookup readout with random masks
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < W; k++) mask_a_i[16*k +: 16] = 16'($urandom);
      mask_b_i = '0;
      cin_i = 1'b0;
      din_i = (W*4)'({$urandom, $urandom});
      #1;
      check("R1 lut read", 64'(sum_o), 64'(lut_vec(mask_a_i, din_i)));
      tick("R7 load");
    end

    // R2/R3/R4: random masks, random carry
    for (int t = 0; t < 200; t++) begin
      for (int k = 0; k < W; k++) begin
        mask_a_i[16*k +: 16] = 16'($urandom);
        mask_b_i[16*k +: 16] = 16'($urandom);
      end
      din_i = (W*4)'({$urandom, $urandom});
      cin_i = 1'($urandom);
      tick("R7 load");
    end

    // R3: full propagate across every slice
    mask_a_i = {W{fmask(4)}};
    mask_b_i = {W{fmask(5)}};
    for (int t = 0; t < 4; t++) begin
      cin_i = 1'(t);
      #1;
      check("R3 propagate sum", 64'(sum_o), cin_i ? 64'h0 : 64'(WMASK));
      check("R3 propagate cout", 64'(cout_o), 64'(cin_i));
      tick("R7 load");
    end

    // R4: adder/subtractor against integer arithmetic
    mask_a_i = {W{fmask(0)}};
    mask_b_i = {W{fmask(1)}};
    for (int t = 0; t < 300; t++) begin
      logic [W-1:0] a, b;
      logic sub;
      a = W'($urandom);
      b = (t % 3 == 0) ? a ^ W'(1 << ($urandom % W)) : W'($urandom);
      sub = 1'($urandom);
      set_din(a, b, {W{sub}}, '0);
      cin_i = sub;
      #1;
      check("R4 addsub", 64'(sum_o), 64'(sub ? W'(a - b) : W'(a + b)));
      check("R4 carry", 64'(cout_o), sub ? 64'(a >= b) : 64'((int'(a) + int'(b)) >> W));
      tick("R7 load");
    end

    // R5/R6: hold and synchronous clear
    set_din(W'(8'h5a), W'(8'h33), '0, '0);
    cin_i = 1'b1;
    tick("R7 load");
    ce_i = 1'b0;
    set_din(W'(8'h11), W'(8'h22), '0, '0);
    tick("R5 hold");
    sclr_i = 1'b1;
    tick("R6 clear ignored");
    check("R6 nonzero kept", 64'(q_o != 0), 64'h1);
    ce_i = 1'b1;
    tick("R6 clear");
    sclr_i = 1'b0;

    // R10: up/down counter with enable, feedback from q_o
    mask_a_i = {W{fmask(2)}};
    mask_b_i = {W{fmask(3)}};
    begin
      logic [W-1:0] cnt;
      cnt = q_o;
      for (int t = 0; t < 600; t++) begin
        logic en, up;
        en = ($urandom % 4) != 0;
        up = (t < 200) ? 1'b0 : ((t < 500) ? 1'b1 : 1'($urandom));
        set_din({W{up}}, {W{en}}, '0, q_o);
        cin_i = en & up;
        tick("R7 load");
        if (en) cnt = up ? cnt + 1'b1 : cnt - 1'b1;
        check("R10 count", 64'(q_o), 64'(cnt));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule